// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filtering

This block is a serial port of the kind found beside a small 8-bit processor core. One 8-bit control register selects one of four framing modes. In the shift mode, eight bits move synchronously and the port supplies the shift clock. In the 8-bit asynchronous mode, the frame has a start bit, eight data bits and a stop bit. In the two 9-bit asynchronous modes, a ninth data bit sits in front of the stop bit. A register port gives software access to the control register and to a data register. Writing the data register starts a transmission. Reading it returns the last byte received.

Software sees a sticky transmit flag and a sticky receive flag. The interrupt output is high while either flag is set. In the asynchronous modes a filter can hold back the receive flag. With the filter enabled, the flag sets in the 9-bit modes only when the ninth bit is 1, and in the 8-bit mode only when the stop bit is 1. This lets a listener skip frames that are not addressed to it. Bit timing comes from an external tick. An asynchronous bit lasts `OVS` ticks, and a shift-mode bit lasts two ticks.

Top module: `mpsp_top`

## Requirements
- R1: After reset the control register reads 00h, `irq` is 0, `txd` is 1 and `rx_oe` is 0.
- R2: Control bits [7:6] select the mode: 00 is shift mode, 01 is 8-bit asynchronous, and 10 and 11 are 9-bit asynchronous. Bit 5 enables the address filter, bit 4 enables reception, bit 3 is the ninth bit to send, bit 2 is the ninth bit received, bit 1 is the transmit flag and bit 0 is the receive flag. Register address 0 is control and address 1 is data, and a read returns its value one clock later.
- R3: An asynchronous transmission drives `txd` with a low start bit, then the data LSB first, then (in the 9-bit modes only) control bit 3, then a high stop bit. Each bit lasts `OVS` ticks and the line idles high.
- R4: In the asynchronous modes the transmit flag sets on the edge where the stop bit begins. In shift mode it sets on the edge that ends the eighth bit.
- R5: In shift mode a transmission drives `rx_out` with `rx_oe` high, LSB first, and drives the shift clock on `txd`. The clock is low for one tick and high for one tick per bit. Data changes only on the falling clock edge.
- R6: In the asynchronous modes, reception starts on a falling edge of `rx_in` and samples each bit near mid-bit. On the mid-stop-bit sample of an accepted frame, the byte is loaded into the data register and the receive flag sets.
- R7: In the 8-bit mode with the filter off, a frame is accepted whatever its stop bit, and bit 2 takes the stop level. With the filter on, a frame whose stop bit is 0 is dropped and the data register and flag are unchanged.
- R8: In the 9-bit modes, bit 2 takes the received ninth bit. With the filter on, only frames whose ninth bit is 1 are accepted.
- R9: With bit 4 at 0, a frame on `rx_in` leaves the receive flag and the data register unchanged.
- R10: In shift mode with bit 4 at 1 and the receive flag at 0, the port runs eight clocks on `txd` and samples `rx_in` on each rising edge. After the eighth it sets the receive flag, loads the byte, and runs no more clocks while the flag stays set.
- R11: Flags are cleared only by a software write to the control register. When hardware sets a flag in the same cycle that a write clears it, the flag ends set.
- R12: `irq` equals the OR of the transmit and receive flags.
- R13: A data-register write while a transmission is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 data |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 data |
| rd_data | output | 8 | Registered read data |
| baud_tick | input | 1 | One-cycle bit-timing tick |
| rx_in | input | 1 | Serial receive line (shift-mode data in) |
| txd | output | 1 | Serial transmit line, or the shift clock in shift mode |
| rx_out | output | 1 | Shift-mode transmit data |
| rx_oe | output | 1 | Enable for `rx_out` |
| irq | output | 1 | Interrupt, OR of the two flags |

## Verification
The transmit-flag set from the engine can land in the same cycle as a software write that clears that flag. The bench counts ticks from the start of a frame in its own model. It places a clearing control write exactly in the cycle whose tick starts the stop bit, then expects `irq` to be high afterwards. A later ordinary clear must then bring it low again. A second overlap is a data write that arrives mid-frame. The per-clock line comparison must show the frame running on undisturbed.

// File: rtl/mpsp_pkg.sv
`timescale 1ns/1ps
package mpsp_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_ASYNC8 = 2'b01,
    MODE_NINE_A = 2'b10,
    MODE_NINE_B = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  mpen;
    logic  ren;
    logic  txb9;
    logic  rxb9;
    logic  tif;
    logic  rif;
  } ctrl_t;

  function automatic logic is_nine(input mode_e m);
    return (m == MODE_NINE_A) || (m == MODE_NINE_B);
  endfunction
endpackage

// File: rtl/mpsp_regs.sv
`timescale 1ns/1ps
module mpsp_regs
  import mpsp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  input  logic          ti_set,
  input  logic          rx_done,
  input  logic          rx_b9,
  input  logic [DW-1:0] rx_byte,
  output ctrl_t         ctrl_q,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  ctrl_t         c_nxt;
  logic [DW-1:0] rbuf;

  // hardware set is applied after the software write, so it wins
  always_comb begin
    c_nxt = ctrl_q;
    if (wr_en && !wr_addr) c_nxt = ctrl_t'(wr_data);
    if (rx_done && ctrl_q.mode != MODE_SHIFT) c_nxt.rxb9 = rx_b9;
    if (ti_set)  c_nxt.tif = 1'b1;
    if (rx_done) c_nxt.rif = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rbuf    <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      ctrl_q  <= c_nxt;
      irq     <= c_nxt.tif | c_nxt.rif;
      rd_data <= rd_addr ? rbuf : ctrl_q;
      if (rx_done) rbuf <= rx_byte;
    end
  end
endmodule

// File: rtl/mpsp_tx.sv
`timescale 1ns/1ps
module mpsp_tx
  import mpsp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  mode_e         mode,
  input  logic [DW-1:0] din,
  input  logic          b9,
  output logic          busy,
  output logic          line_q,
  output logic          dat_q,
  output logic          dat_oe,
  output logic          ti_set
);
  localparam int FW = DW + 3;
  localparam int IW = $clog2(FW);
  localparam int CW = $clog2(OVS);

  logic [FW-1:0] fr;
  logic [IW-1:0] bidx, last;
  logic [CW-1:0] tcnt;
  logic          m0, ph;

  always_comb begin
    ti_set = 1'b0;
    if (busy && tick) begin
      if (m0) ti_set = ph && (bidx == IW'(DW-1));
      else    ti_set = (tcnt == CW'(OVS-1)) && ((bidx + IW'(1)) == last);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; line_q <= 1'b1; dat_q <= 1'b0; dat_oe <= 1'b0;
      fr <= '0; bidx <= '0; last <= '0; tcnt <= '0; m0 <= 1'b0; ph <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        bidx <= '0;
        tcnt <= '0;
        ph   <= 1'b0;
        m0   <= (mode == MODE_SHIFT);
        fr   <= {1'b1, (is_nine(mode) ? b9 : 1'b1), din, 1'b0};
        last <= is_nine(mode) ? IW'(DW+2) : IW'(DW+1);
        if (mode == MODE_SHIFT) begin
          line_q <= 1'b1;
          dat_q  <= din[0];
          dat_oe <= 1'b1;
        end else begin
          line_q <= 1'b0;
        end
      end
    end else if (tick) begin
      if (m0) begin
        if (!ph) begin
          line_q <= 1'b0;
          dat_q  <= fr[bidx + IW'(1)];
          ph     <= 1'b1;
        end else begin
          line_q <= 1'b1;
          ph     <= 1'b0;
          if (bidx == IW'(DW-1)) begin
            busy   <= 1'b0;
            dat_oe <= 1'b0;
          end else begin
            bidx <= bidx + IW'(1);
          end
        end
      end else if (tcnt == CW'(OVS-1)) begin
        tcnt <= '0;
        if (bidx == last) begin
          busy   <= 1'b0;
          line_q <= 1'b1;
        end else begin
          bidx   <= bidx + IW'(1);
          line_q <= fr[bidx + IW'(1)];
        end
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mpsp_rx.sv
`timescale 1ns/1ps
module mpsp_rx
  import mpsp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          pin,
  input  mode_e         mode,
  input  logic          mpen,
  input  logic          ren,
  input  logic          rif,
  input  logic          hold,
  output logic          done,
  output logic          b9_o,
  output logic [DW-1:0] byte_o,
  output logic          sclk_q,
  output logic          sclk_act,
  output logic          busy
);
  localparam int IW  = $clog2(DW + 3);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;

  logic          s1, s2, s3, act, m0, ph, n9, b9;
  logic [IW-1:0] bidx;
  logic [CW-1:0] tcnt;
  logic [DW-1:0] sh;
  logic          fall, mid, stop_pt;

  assign fall     = s3 & ~s2;
  assign mid      = act && !m0 && tick && (tcnt == CW'(MID));
  assign stop_pt  = mid && (bidx == (n9 ? IW'(DW+2) : IW'(DW+1)));
  assign busy     = act;
  assign sclk_act = act & m0;

  always_comb begin
    done   = 1'b0;
    b9_o   = s2;
    byte_o = sh;
    if (act && m0) begin
      byte_o = {s2, sh[DW-1:1]};
      done   = tick && ph && (bidx == IW'(DW-1));
    end else if (stop_pt) begin
      b9_o = n9 ? b9 : s2;
      done = !mpen || (n9 ? b9 : s2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      act <= 1'b0; m0 <= 1'b0; ph <= 1'b0; n9 <= 1'b0; b9 <= 1'b0;
      bidx <= '0; tcnt <= '0; sh <= '0; sclk_q <= 1'b1;
    end else begin
      s1 <= pin; s2 <= s1; s3 <= s2;
      if (!act) begin
        if (ren) begin
          if (mode == MODE_SHIFT) begin
            if (!rif && !hold) begin
              act <= 1'b1; m0 <= 1'b1; bidx <= '0; ph <= 1'b0; sclk_q <= 1'b1;
            end
          end else if (fall) begin
            act <= 1'b1; m0 <= 1'b0; tcnt <= '0; bidx <= '0; n9 <= is_nine(mode);
          end
        end
      end else if (m0) begin
        if (tick) begin
          if (!ph) begin
            sclk_q <= 1'b0;
            ph     <= 1'b1;
          end else begin
            sclk_q <= 1'b1;
            ph     <= 1'b0;
            sh     <= {s2, sh[DW-1:1]};
            if (bidx == IW'(DW-1)) act <= 1'b0;
            else bidx <= bidx + IW'(1);
          end
        end
      end else if (tick) begin
        tcnt <= (tcnt == CW'(OVS-1)) ? '0 : tcnt + CW'(1);
        if (tcnt == CW'(MID)) begin
          bidx <= bidx + IW'(1);
          if (bidx == '0) begin
            if (s2) act <= 1'b0;
          end else if (bidx <= IW'(DW)) begin
            sh <= {s2, sh[DW-1:1]};
          end else if (stop_pt) begin
            act <= 1'b0;
          end else begin
            b9 <= s2;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mpsp_top.sv
`timescale 1ns/1ps
module mpsp_top
  import mpsp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          baud_tick,
  input  logic          rx_in,
  output logic          txd,
  output logic          rx_out,
  output logic          rx_oe,
  output logic          irq
);
  ctrl_t         ctrl_q;
  logic          ti_set, tx_busy_w, tx_line;
  logic          rx_done, rx_b9, rx_sclk, sclk_act, rx_busy_w;
  logic [DW-1:0] rx_byte;
  logic          tif_w, rif_w, ren_w;

  assign tif_w = ctrl_q.tif;
  assign rif_w = ctrl_q.rif;
  assign ren_w = ctrl_q.ren;

  mpsp_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ti_set(ti_set), .rx_done(rx_done), .rx_b9(rx_b9),
    .rx_byte(rx_byte), .ctrl_q(ctrl_q), .rd_data(rd_data), .irq(irq)
  );

  mpsp_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .start(wr_en && wr_addr),
    .mode(ctrl_q.mode), .din(wr_data), .b9(ctrl_q.txb9), .busy(tx_busy_w),
    .line_q(tx_line), .dat_q(rx_out), .dat_oe(rx_oe), .ti_set(ti_set)
  );

  mpsp_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .pin(rx_in), .mode(ctrl_q.mode),
    .mpen(ctrl_q.mpen), .ren(ctrl_q.ren), .rif(ctrl_q.rif), .hold(tx_busy_w),
    .done(rx_done), .b9_o(rx_b9), .byte_o(rx_byte), .sclk_q(rx_sclk),
    .sclk_act(sclk_act), .busy(rx_busy_w)
  );

  assign txd = sclk_act ? rx_sclk : tx_line;
endmodule

// File: rtl/mpsp_chk.sv
`timescale 1ns/1ps
module mpsp_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic wr_addr,
  input logic irq,
  input logic txd,
  input logic rx_oe,
  input logic tif,
  input logic rif,
  input logic ti_set,
  input logic ren,
  input logic rx_busy,
  input logic tx_busy,
  input logic sclk_act
);
  // R12
  irq_or_chk: assert property (@(posedge clk) disable iff (rst) irq == (tif | rif));
  // R11
  ti_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tif && !(wr_en && !wr_addr)) |=> tif);
  // R11
  ri_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rif && !(wr_en && !wr_addr)) |=> rif);
  // R11
  ti_wins_chk: assert property (@(posedge clk) disable iff (rst) ti_set |=> tif);
  // R4
  ti_in_frame_chk: assert property (@(posedge clk) disable iff (rst) ti_set |-> tx_busy);
  // R9
  ren_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ren && !rx_busy) |=> !rx_busy);
  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && !sclk_act) |-> txd);
  // R5
  oe_busy_chk: assert property (@(posedge clk) disable iff (rst) rx_oe |-> tx_busy);
endmodule

bind mpsp_top mpsp_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .irq(irq), .txd(txd),
  .rx_oe(rx_oe), .tif(tif_w), .rif(rif_w), .ti_set(ti_set), .ren(ren_w),
  .rx_busy(rx_busy_w), .tx_busy(tx_busy_w), .sclk_act(sclk_act)
);

// File: tb/tb_mpsp_top.sv
`timescale 1ns/1ps
module tb_mpsp_top;
  localparam int OVS  = 16;
  localparam int TPER = 4;
  localparam int BITC = OVS * TPER;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       baud_tick = 1'b0, rx_in = 1'b1;
  logic       txd, rx_out, rx_oe, irq;

  always #2.5 clk = ~clk;

  mpsp_top #(.OVS(OVS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .baud_tick(baud_tick), .rx_in(rx_in),
    .txd(txd), .rx_out(rx_out), .rx_oe(rx_oe), .irq(irq)
  );

  int checks = 0, fails = 0, ph4 = 0;

  // behavioural transmit model: ticks since start, expected frame bits
  bit         mdl_on = 0, mdl_armed = 0, mdl_m0 = 0;
  int         mdl_n = 0;
  bit         mdl_bits[$];
  bit [7:0]   mdl_d;
  string      mdl_tag = "R3";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    if (mdl_on) begin
      if (mdl_armed && baud_tick) mdl_n++;
      mdl_armed = 1;
      if (mdl_m0) begin
        if (mdl_n < 16) begin
          chk(txd == ((mdl_n == 0) ? 1'b1 : ((mdl_n % 2) ? 1'b0 : 1'b1)), "R5 clock", txd, mdl_n);
          chk(rx_out == mdl_d[(mdl_n == 0) ? 0 : (mdl_n - 1) / 2], "R5 data", rx_out, mdl_n);
          chk(rx_oe == 1'b1, "R5 oe", rx_oe, 1);
        end else begin
          chk(rx_oe == 1'b0 && txd == 1'b1, "R5 end", {rx_oe, txd}, 1);
        end
        chk(irq == (mdl_n >= 16), "R4 R12", irq, mdl_n >= 16);
        if (mdl_n >= 17) mdl_on = 0;
      end else begin
        if (mdl_n < OVS * mdl_bits.size())
          chk(txd == mdl_bits[mdl_n / OVS], mdl_tag, txd, mdl_bits[mdl_n / OVS]);
        else
          chk(txd == 1'b1, mdl_tag, txd, 1);
        chk(irq == (mdl_n >= OVS * (mdl_bits.size() - 1)), "R4 R12", irq, mdl_n);
        if (mdl_n >= OVS * mdl_bits.size() + 1) mdl_on = 0;
      end
    end
    baud_tick = (ph4 == TPER - 1);
    ph4 = (ph4 + 1) % TPER;
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic rd_chk(input bit a, input logic [7:0] exp, input string req);
    rd_addr = a;
    cyc();
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic start_tx(input logic [7:0] d, input bit m0, input bit nine, input bit b9);
    mdl_bits.delete();
    mdl_bits.push_back(0);
    for (int i = 0; i < 8; i++) mdl_bits.push_back(d[i]);
    if (nine) mdl_bits.push_back(b9);
    mdl_bits.push_back(1);
    mdl_d = d; mdl_m0 = m0; mdl_n = 0; mdl_armed = 0; mdl_on = 1; mdl_tag = "R3";
    wr(1'b1, d);
  endtask

  task automatic wait_model();
    for (int k = 0; k < 2000 && mdl_on; k++) cyc();
  endtask

  task automatic send_async(input logic [7:0] d, input bit nine, input bit b9, input bit stp);
    bit q[$];
    q.push_back(0);
    for (int i = 0; i < 8; i++) q.push_back(d[i]);
    if (nine) q.push_back(b9);
    q.push_back(stp);
    foreach (q[i]) begin
      rx_in = q[i];
      repeat (BITC) cyc();
    end
    rx_in = 1;
    repeat (24) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk(irq == 0 && txd == 1 && rx_oe == 0, "R1", {irq, txd, rx_oe}, 3'b010);
    rd_chk(0, 8'h00, "R1");

    // R2 R3 R13: 8-bit frame, with a data write arriving mid-frame
    wr(0, 8'h40);
    start_tx(8'hA5, 0, 0, 0);
    repeat (200) cyc();
    mdl_tag = "R13";
    wr(1, 8'hFF);
    wait_model();
    rd_chk(0, 8'h42, "R4");
    wr(0, 8'h40);
    cyc();
    chk(irq == 0, "R11 clear", irq, 0);

    // R2 R3: 9-bit frames, ninth bit taken from control bit 3
    wr(0, 8'hC8);
    start_tx(8'h3C, 0, 1, 1);
    wait_model();
    wr(0, 8'h80);
    start_tx(8'hF0, 0, 1, 0);
    wait_model();
    wr(0, 8'h00);

    // R5: shift-mode transmit
    start_tx(8'h96, 1, 0, 0);
    wait_model();
    rd_chk(0, 8'h02, "R4 shift");
    wr(0, 8'h40);

    // R11: clearing write lands in the cycle the stop bit begins
    start_tx(8'h55, 0, 0, 0);
    while (!(mdl_n == OVS * 9 - 1 && baud_tick)) cyc();
    wr(0, 8'h40);
    chk(irq == 1, "R11 collision", irq, 1);
    wait_model();
    repeat (50) cyc();
    chk(irq == 1, "R11 sticky", irq, 1);
    wr(0, 8'h40);
    cyc();
    chk(irq == 0, "R11 sw clear", irq, 0);

    // R6 R7: 8-bit receive, filter off, good stop
    wr(0, 8'h50);
    send_async(8'h3A, 0, 0, 1);
    chk(irq == 1, "R6 R12", irq, 1);
    rd_chk(1, 8'h3A, "R6");
    rd_chk(0, 8'h55, "R7");
    // R7: filter off, stop 0 still accepted, RB8 = 0
    wr(0, 8'h50);
    send_async(8'hC3, 0, 0, 0);
    rd_chk(1, 8'hC3, "R7 stop ignored");
    rd_chk(0, 8'h51, "R7 stop ignored");
    // R7: filter on, stop 0 dropped
    wr(0, 8'h70);
    send_async(8'h11, 0, 0, 0);
    chk(irq == 0, "R7 filtered", irq, 0);
    rd_chk(1, 8'hC3, "R7 filtered");
    // R8: 9-bit, filter on
    wr(0, 8'hF0);
    send_async(8'h22, 1, 0, 1);
    chk(irq == 0, "R8 ninth 0", irq, 0);
    rd_chk(1, 8'hC3, "R8 ninth 0");
    send_async(8'h5D, 1, 1, 1);
    rd_chk(1, 8'h5D, "R8 ninth 1");
    rd_chk(0, 8'hF5, "R8 ninth 1");
    // R8: filter off, ninth 0 accepted
    wr(0, 8'h90);
    send_async(8'h81, 1, 0, 1);
    rd_chk(1, 8'h81, "R8 no filter");
    rd_chk(0, 8'h91, "R8 no filter");
    // R9: receive disabled
    wr(0, 8'h40);
    send_async(8'h77, 0, 0, 1);
    chk(irq == 0, "R9", irq, 0);
    rd_chk(1, 8'h81, "R9");

    // R10: shift-mode receive
    begin
      logic [7:0] b = 8'h6B;
      int  falls = 0;
      bit  prev = 1;
      int  lows = 0;
      rx_in = b[0];
      wr(0, 8'h10);
      for (int k = 0; k < 400 && !irq; k++) begin
        cyc();
        if (prev && !txd) begin
          falls++;
          if (falls >= 2 && falls <= 8) rx_in = b[falls - 1];
        end
        prev = txd;
      end
      chk(irq == 1, "R10 flag", irq, 1);
      rd_chk(1, 8'h6B, "R10 byte");
      rd_chk(0, 8'h11, "R10 ctrl");
      for (int k = 0; k < 40; k++) begin
        cyc();
        if (!txd) lows++;
      end
      chk(lows == 0, "R10 stopped", lows, 0);
      rx_in = 1;
      wr(0, 8'h00);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule